// File: doc/BRIEF.md
# CAN Controller Interrupt and Status Unit

This unit holds the interrupt bookkeeping of a CAN controller and drives the controller's interrupt pin. Other parts of the controller report events to it as single-cycle pulses on an eight-bit source vector. There is one bit for each of these:
- a message error,
- a wake-up on bus activity,
- a change in the error-flag state,
- each of three transmit buffers becoming empty,
- each of two receive buffers becoming full.

Each event sets a sticky pending flag. An enable mask decides which pending flags may pull the active-low interrupt output low. The host reaches the enable byte, the flag byte and a read-only status byte through a byte-wide register bus. The bus supports plain writes and a masked bit-modify write.

The status byte holds two fields. The first is a 3-bit code naming the highest-priority source that is both pending and enabled. The second is the current operating mode. The mode is handled by a small state machine with five states: `MODE_NORMAL`, `MODE_SLEEP`, `MODE_LOOPBACK`, `MODE_LISTEN` and `MODE_CONFIG`. A single transition rule applies from every state: on a `mode_done` strobe carrying a legal request, move to the requested state. With no strobe, or with an illegal request, the machine stays where it is. Two extra active-low outputs follow the two receive-full flags directly.

Top module: `can_irq_status`

## Requirements
- R1: After reset the unit is in this state:
  - The enable byte (address 0x2B) and the flag byte (address 0x2C) read 0x00.
  - The status byte (address 0x0E) reads 0x80.
  - `irq_n`, `rx0_full_n` and `rx1_full_n` are all 1.
  - Any other address reads 0x00.
- R2: A 1 on bit i of `ev_src` during a clock edge sets flag bit i at that edge. The flag stays set until the host clears it. The bit positions are: 7 message error, 6 wake-up, 5 error change, 4 TX2 empty, 3 TX1 empty, 2 TX0 empty, 1 RX1 full, 0 RX0 full. The enable byte uses the same positions.
- R3: The enable byte takes its new value from two kinds of write:
  - A plain write (`bus_wr`=1, `bus_mod`=0) replaces the whole byte.
  - A bit-modify write (`bus_wr`=1, `bus_mod`=1) replaces only the bits where `bus_mask` is 1.
- R4: A plain write to the flag byte clears each flag whose data bit is 0. A write never sets a flag.
- R5: A bit-modify write to the flag byte clears only those flags whose mask bit is 1 and data bit is 0. All other flags are left unchanged.
- R6: If an event and a clearing write hit the same flag in the same cycle, the event wins and the flag ends up set.
- R7: `irq_n` is registered:
  - It goes low one clock after any flag bit and its matching enable bit are both 1.
  - It returns high one clock after no such pair remains.
- R8: The status byte carries an interrupt code in bits 3:1, taken from the flags that are both pending and enabled:
  - The code names the highest-priority such source. The priority order is error change (001), wake-up (010), TX0 (011), TX1 (100), TX2 (101), RX0 (110), RX1 (111).
  - The code is 000 when none of these sources is both pending and enabled.
  - The message-error source never sets the code.
- R9: The status byte reads {mode[2:0], 0, code[2:0], 0`}. Bits 4 and 0 always read 0.
- R10: `rx0_full_n` equals the inverse of flag bit 0, and `rx1_full_n` equals the inverse of flag bit 1, whatever the enable byte holds.
- R11: The mode field changes only at an edge where `mode_done` is 1:
  - It then takes `mode_req` if that value is one of 000 normal, 001 sleep, 010 loopback, 011 listen-only or 100 configuration.
  - Any other request value leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_mod | input | 1 | With `bus_wr`, selects a masked bit-modify write |
| bus_wdata | input | 8 | Write data |
| bus_mask | input | 8 | Bit mask for bit-modify writes |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ev_src | input | 8 | Event pulses, one bit per source |
| mode_req | input | 3 | Requested operating mode |
| mode_done | input | 1 | Strobe that applies `mode_req` |
| irq_n | output | 1 | Active-low interrupt, registered |
| rx0_full_n | output | 1 | Active-low RX buffer 0 full |
| rx1_full_n | output | 1 | Active-low RX buffer 1 full |

## Verification
Two things can land on the same flag in one cycle: an event pulse from the controller and a clearing write from the host. The bench creates this overlap by driving a TX0-empty pulse in the same cycle as a flag write of 0x00, after first setting several other flags. It then reads the flag byte back. The check passes only if the TX0 bit is still set while every other flag has been cleared. The flag byte is also read again afterwards, to confirm that the surviving bit stays set once the event is gone.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int NUM_SRC = 8;
    localparam int CODE_W  = 3;
    localparam int MODE_W  = 3;

    // Source bit positions in the enable and flag bytes
    localparam int SRC_RX0  = 0;
    localparam int SRC_RX1  = 1;
    localparam int SRC_TX0  = 2;
    localparam int SRC_TX1  = 3;
    localparam int SRC_TX2  = 4;
    localparam int SRC_ERR  = 5;
    localparam int SRC_WAKE = 6;
    localparam int SRC_MERR = 7;

    // Interrupt codes reported in the status byte
    localparam logic [CODE_W-1:0] CODE_NONE = 3'd0;
    localparam logic [CODE_W-1:0] CODE_ERR  = 3'd1;
    localparam logic [CODE_W-1:0] CODE_WAKE = 3'd2;
    localparam logic [CODE_W-1:0] CODE_TX0  = 3'd3;
    localparam logic [CODE_W-1:0] CODE_TX1  = 3'd4;
    localparam logic [CODE_W-1:0] CODE_TX2  = 3'd5;
    localparam logic [CODE_W-1:0] CODE_RX0  = 3'd6;
    localparam logic [CODE_W-1:0] CODE_RX1  = 3'd7;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL   = 3'b000,
        MODE_SLEEP    = 3'b001,
        MODE_LOOPBACK = 3'b010,
        MODE_LISTEN   = 3'b011,
        MODE_CONFIG   = 3'b100
    } op_mode_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import can_irq_pkg::*;
#(
    parameter int WIDTH = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             fl_wr,
    input  logic             masked,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] ev,
    output logic [WIDTH-1:0] en_q,
    output logic [WIDTH-1:0] fl_q
);

    // A plain write behaves as a bit-modify with every mask bit set
    logic [WIDTH-1:0] eff_mask;
    assign eff_mask = masked ? mask : {WIDTH{1'b1}};

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic en_d;
        logic fl_d;
        logic fl_clr;

        always_comb begin
            en_d = en_q[b];
            if (en_wr && eff_mask[b]) begin
                en_d = wdata[b];
            end
        end

        // Host may only clear a flag; an event in the same cycle wins
        assign fl_clr = fl_wr && eff_mask[b] && !wdata[b];

        always_comb begin
            fl_d = fl_q[b];
            if (fl_clr) begin
                fl_d = 1'b0;
            end
            if (ev[b]) begin
                fl_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[b] <= 1'b0;
                fl_q[b] <= 1'b0;
            end else begin
                en_q[b] <= en_d;
                fl_q[b] <= fl_d;
            end
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import can_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output logic [CODE_W-1:0]  code
);

    // Fixed priority: error, wake-up, TX0, TX1, TX2, RX0, RX1.
    // The message-error source is not encoded.
    always_comb begin
        if (pend[SRC_ERR]) begin
            code = CODE_ERR;
        end else if (pend[SRC_WAKE]) begin
            code = CODE_WAKE;
        end else if (pend[SRC_TX0]) begin
            code = CODE_TX0;
        end else if (pend[SRC_TX1]) begin
            code = CODE_TX1;
        end else if (pend[SRC_TX2]) begin
            code = CODE_TX2;
        end else if (pend[SRC_RX0]) begin
            code = CODE_RX0;
        end else if (pend[SRC_RX1]) begin
            code = CODE_RX1;
        end else begin
            code = CODE_NONE;
        end
    end

endmodule

// File: rtl/op_mode_fsm.sv
module op_mode_fsm
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] req,
    input  logic              done,
    output logic [MODE_W-1:0] mode
);

    op_mode_e state_q;
    op_mode_e state_d;
    logic     req_legal;

    assign req_legal = (req <= MODE_CONFIG);

    // Next-state logic: every state moves to a legal request on the strobe
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL, MODE_SLEEP, MODE_LOOPBACK, MODE_LISTEN, MODE_CONFIG: begin
                if (done && req_legal) begin
                    state_d = op_mode_e'(req);
                end
            end
            default: begin
                state_d = MODE_CONFIG;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_CONFIG;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        mode = state_q;
    end

endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
    import can_irq_pkg::*;
#(
    parameter logic [7:0] EN_ADDR   = 8'h2B,
    parameter logic [7:0] FLAG_ADDR = 8'h2C,
    parameter logic [7:0] STAT_ADDR = 8'h0E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_mod,
    input  logic [7:0] bus_wdata,
    input  logic [7:0] bus_mask,
    output logic [7:0] bus_rdata,
    input  logic [7:0] ev_src,
    input  logic [2:0] mode_req,
    input  logic       mode_done,
    output logic       irq_n,
    output logic       rx0_full_n,
    output logic       rx1_full_n
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] pend;
    logic [CODE_W-1:0]  irq_code;
    logic [MODE_W-1:0]  mode_q;
    logic               en_sel;
    logic               fl_sel;

    assign en_sel = bus_wr && (bus_addr == EN_ADDR);
    assign fl_sel = bus_wr && (bus_addr == FLAG_ADDR);

    irq_flag_bank #(.WIDTH(NUM_SRC)) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (en_sel),
        .fl_wr  (fl_sel),
        .masked (bus_mod),
        .wdata  (bus_wdata),
        .mask   (bus_mask),
        .ev     (ev_src),
        .en_q   (en_q),
        .fl_q   (flag_q)
    );

    assign pend = flag_q & en_q;

    irq_prio_enc enc_i (
        .pend (pend),
        .code (irq_code)
    );

    op_mode_fsm mode_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mode_req),
        .done  (mode_done),
        .mode  (mode_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ~(|pend);
        end
    end

    assign rx0_full_n = ~flag_q[SRC_RX0];
    assign rx1_full_n = ~flag_q[SRC_RX1];

    always_comb begin
        if (bus_addr == EN_ADDR) begin
            bus_rdata = en_q;
        end else if (bus_addr == FLAG_ADDR) begin
            bus_rdata = flag_q;
        end else if (bus_addr == STAT_ADDR) begin
            bus_rdata = {mode_q, 1'b0, irq_code, 1'b0};
        end else begin
            bus_rdata = 8'h00;
        end
    end

endmodule

// File: rtl/can_irq_status_chk.sv
module can_irq_status_chk #(
    parameter logic [7:0] FLAG_ADDR = 8'h2C
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] ev_src,
    input logic [7:0] flags,
    input logic [7:0] enables,
    input logic       irq_n,
    input logic       mode_done,
    input logic [2:0] mode_bits,
    input logic [2:0] code
);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == FLAG_ADDR) |=> ((flags & $past(flags)) == $past(flags))); // R2

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_src != 8'h00) |=> ((flags & $past(ev_src)) == $past(ev_src))); // R6

    AST_IRQ_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & enables) != 8'h00) |=> !irq_n); // R7

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & enables) == 8'h00) |=> irq_n); // R7

    AST_CODE_NO_MERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & enables) == 8'h80) |-> (code == 3'd0)); // R8

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_done |=> $stable(mode_bits)); // R11

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bits <= 3'b100); // R11

endmodule

bind can_irq_status can_irq_status_chk #(.FLAG_ADDR(FLAG_ADDR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .ev_src    (ev_src),
    .flags     (flag_q),
    .enables   (en_q),
    .irq_n     (irq_n),
    .mode_done (mode_done),
    .mode_bits (mode_q),
    .code      (irq_code)
);

// File: tb/can_irq_status_tb.sv
module can_irq_status_tb_top;

    localparam logic [7:0] A_EN   = 8'h2B;
    localparam logic [7:0] A_FLAG = 8'h2C;
    localparam logic [7:0] A_STAT = 8'h0E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_mod = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_mask = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] ev_src = 8'h00;
    logic [2:0] mode_req = 3'b000;
    logic       mode_done = 1'b0;
    logic       irq_n;
    logic       rx0_full_n;
    logic       rx1_full_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    can_irq_status dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_mod    (bus_mod),
        .bus_wdata  (bus_wdata),
        .bus_mask   (bus_mask),
        .bus_rdata  (bus_rdata),
        .ev_src     (ev_src),
        .mode_req   (mode_req),
        .mode_done  (mode_done),
        .irq_n      (irq_n),
        .rx0_full_n (rx0_full_n),
        .rx1_full_n (rx1_full_n)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] addr, output logic [7:0] val);
        @(negedge clk);
        bus_addr = addr;
        #1 val = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data,
                      input logic modify, input logic [7:0] mask);
        @(negedge clk);
        bus_addr = addr; bus_wdata = data; bus_mod = modify; bus_mask = mask; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_mod = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk);
        ev_src = ev;
        @(negedge clk);
        ev_src = 8'h00;
    endtask

    function automatic logic [7:0] stat(input logic [2:0] m, input logic [2:0] c);
        return {m, 1'b0, c, 1'b0};
    endfunction

    task automatic t_reset;
        logic [7:0] v;
        rd(A_EN, v);   chk("R1 enable reset", v, 8'h00);
        rd(A_FLAG, v); chk("R1 flag reset", v, 8'h00);
        rd(A_STAT, v); chk("R1 status reset", v, 8'h80);
        rd(8'h55, v);  chk("R1 unmapped read", v, 8'h00);
        chk("R1 irq_n reset", {7'd0, irq_n}, 8'h01);
        chk("R1 rx full reset", {6'd0, rx1_full_n, rx0_full_n}, 8'h03);
    endtask

    task automatic t_sticky;
        logic [7:0] v;
        logic [7:0] acc = 8'h00;
        for (int i = 0; i < 8; i++) begin
            pulse(8'h01 << i);
            acc = acc | (8'h01 << i);
            rd(A_FLAG, v); chk("R2 flag set and held", v, acc);
        end
        wr(A_FLAG, 8'h00, 1'b0, 8'h00);
        rd(A_FLAG, v); chk("R4 clear all flags", v, 8'h00);
    endtask

    task automatic t_enable;
        logic [7:0] v;
        wr(A_EN, 8'hA5, 1'b0, 8'h00);
        rd(A_EN, v); chk("R3 enable plain write", v, 8'hA5);
        wr(A_EN, 8'hF0, 1'b1, 8'h0F);
        rd(A_EN, v); chk("R3 enable bit-modify", v, 8'hA0);
        wr(A_EN, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic t_flag_write;
        logic [7:0] v;
        pulse(8'hFF);
        wr(A_FLAG, 8'hF0, 1'b0, 8'h00);
        rd(A_FLAG, v); chk("R4 write clears zero bits", v, 8'hF0);
        wr(A_FLAG, 8'hFF, 1'b0, 8'h00);
        rd(A_FLAG, v); chk("R4 write never sets", v, 8'hF0);
        wr(A_FLAG, 8'h10, 1'b1, 8'h30);
        rd(A_FLAG, v); chk("R5 bit-modify clears masked zero", v, 8'hD0);
        wr(A_FLAG, 8'hFF, 1'b1, 8'h0F);
        rd(A_FLAG, v); chk("R5 bit-modify never sets", v, 8'hD0);
        wr(A_FLAG, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        pulse(8'h62);
        @(negedge clk);
        ev_src = 8'h04;
        bus_addr = A_FLAG; bus_wdata = 8'h00; bus_mod = 1'b0; bus_wr = 1'b1;
        @(negedge clk);
        ev_src = 8'h00; bus_wr = 1'b0;
        rd(A_FLAG, v); chk("R6 event beats clear", v, 8'h04);
        rd(A_FLAG, v); chk("R6 surviving flag held", v, 8'h04);
        wr(A_FLAG, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic t_irq;
        wr(A_EN, 8'h04, 1'b0, 8'h00);
        pulse(8'h08);
        @(negedge clk);
        chk("R7 disabled source no irq", {7'd0, irq_n}, 8'h01);
        pulse(8'h04);
        chk("R7 irq_n not yet low", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        chk("R7 irq_n low one clock later", {7'd0, irq_n}, 8'h00);
        wr(A_FLAG, 8'hFB, 1'b0, 8'h00);
        chk("R7 irq_n still low on clear edge", {7'd0, irq_n}, 8'h00);
        @(negedge clk);
        chk("R7 irq_n released", {7'd0, irq_n}, 8'h01);
        wr(A_EN, 8'h0C, 1'b0, 8'h00);
        @(negedge clk);
        chk("R7 enabling pending flag asserts", {7'd0, irq_n}, 8'h00);
        wr(A_FLAG, 8'h00, 1'b0, 8'h00);
        wr(A_EN, 8'h00, 1'b0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_code;
        logic [7:0] v;
        logic [7:0] clr_order [7];
        logic [2:0] exp_code [7];
        logic [7:0] live = 8'hFF;
        clr_order = '{8'h20, 8'h40, 8'h04, 8'h08, 8'h10, 8'h01, 8'h02};
        exp_code  = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
        wr(A_EN, 8'hFF, 1'b0, 8'h00);
        pulse(8'hFF);
        for (int i = 0; i < 7; i++) begin
            rd(A_STAT, v); chk("R8 R9 priority code", v, stat(3'b100, exp_code[i]));
            live = live & ~clr_order[i];
            wr(A_FLAG, live, 1'b0, 8'h00);
        end
        rd(A_STAT, v); chk("R8 message error not coded", v, stat(3'b100, 3'd0));
        @(negedge clk);
        chk("R7 message error drives irq", {7'd0, irq_n}, 8'h00);
        wr(A_EN, 8'h7F, 1'b0, 8'h00);
        pulse(8'h18);
        rd(A_STAT, v); chk("R8 TX1 over TX2", v, stat(3'b100, 3'd4));
        wr(A_EN, 8'h17, 1'b0, 8'h00);
        rd(A_STAT, v); chk("R8 code follows enable", v, stat(3'b100, 3'd5));
        wr(A_FLAG, 8'h00, 1'b0, 8'h00);
        wr(A_EN, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic t_rxfull;
        pulse(8'h01);
        #1;
        chk("R10 rx0 full", {6'd0, rx1_full_n, rx0_full_n}, 8'h02);
        pulse(8'h02);
        #1;
        chk("R10 both rx full", {6'd0, rx1_full_n, rx0_full_n}, 8'h00);
        chk("R10 no irq with enables off", {7'd0, irq_n}, 8'h01);
        wr(A_FLAG, 8'h02, 1'b0, 8'h00);
        #1;
        chk("R10 rx0 released", {6'd0, rx1_full_n, rx0_full_n}, 8'h01);
        wr(A_FLAG, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic mode_step(input logic [2:0] req, input logic strobe);
        @(negedge clk);
        mode_req = req; mode_done = strobe;
        @(negedge clk);
        mode_done = 1'b0;
    endtask

    task automatic t_mode;
        logic [7:0] v;
        mode_step(3'b000, 1'b0);
        rd(A_STAT, v); chk("R11 no strobe no change", v, stat(3'b100, 3'd0));
        mode_step(3'b000, 1'b1);
        rd(A_STAT, v); chk("R11 normal on strobe", v, stat(3'b000, 3'd0));
        mode_step(3'b011, 1'b1);
        rd(A_STAT, v); chk("R11 listen-only", v, stat(3'b011, 3'd0));
        mode_step(3'b110, 1'b1);
        rd(A_STAT, v); chk("R11 illegal request ignored", v, stat(3'b011, 3'd0));
        mode_step(3'b001, 1'b1);
        rd(A_STAT, v); chk("R11 sleep", v, stat(3'b001, 3'd0));
        mode_step(3'b100, 1'b1);
        rd(A_STAT, v); chk("R11 back to config", v, stat(3'b100, 3'd0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sticky();
        t_enable();
        t_flag_write();
        t_collision();
        t_irq();
        t_code();
        t_rxfull();
        t_mode();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule